// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Generation

A purely combinational arithmetic and logic unit for a small accumulator-based processor core. Each evaluation takes a 5-bit operation code, the accumulator value, a second operand and the current flag byte. It returns an 8-bit result and the next flag byte. The surrounding datapath decides whether to write the result back. For compare and the carry operations the result simply equals the accumulator.

Every operation has a fixed policy for each flag: the flag is computed, forced to one, forced to zero or kept. A single flag bit holds signed overflow after arithmetic operations and even parity after logical operations. Increment and decrement work on the second operand, so that any location can be stepped. The rotates and the complement work on the accumulator.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBB=3, CMP=4, NEG=5, AND=6, OR=7, XOR=8, INC=9, DEC=10, ROLC=11, RORC=12, ROL9=13, ROR9=14, NOT=15, STC=16, CMC=17. ADD gives acc+opnd mod 256 and ADDC adds the incoming carry as well. SUB gives acc-opnd mod 256 and SUBB also subtracts the incoming carry. NEG gives 0-acc. CMP gives acc as its result.
- R2: The flag byte is laid out as sign bit 7, zero bit 6, half-carry bit 4, parity/overflow bit 2, add/subtract bit 1 and carry bit 0. Bits 5 and 3 are always copied from the input flag byte to the output.
- R3: Every operation except the rotates, NOT, STC and CMC sets sign to result bit 7 and sets zero when the 8-bit result is 0x00. CMP takes these flags from acc-opnd.
- R4: The add operations set carry on a carry out of bit 7, and set half-carry on a carry from bit 3 into bit 4. SUB, SUBB, CMP and NEG set carry on a borrow out of bit 7, and set half-carry on a borrow from bit 4.
- R5: ADD, ADDC, SUB, SUBB, CMP and NEG place signed two's-complement overflow in bit 2. For example 0x7F+0x01 sets it, 0x80-0x01 sets it, and NEG of 0x80 sets it.
- R6: The add/subtract flag is 1 after SUB, SUBB, CMP, NEG, DEC and NOT. It is 0 after every other defined operation.
- R7: AND clears carry, sets half-carry and writes parity to bit 2. OR and XOR clear carry and half-carry and write parity to bit 2. Parity is 1 when the result has an even number of one bits.
- R8: INC gives opnd+1 and DEC gives opnd-1. Both keep carry and compute half-carry. Overflow is set only for INC of 0x7F and for DEC of 0x80.
- R9: ROLC and RORC rotate acc left and right by one bit. ROL9 and ROR9 rotate through carry: the old carry enters the vacated bit. In all four the carry takes the bit shifted out, half-carry and add/subtract are cleared, and sign, zero and parity/overflow are kept.
- R10: NOT gives ~acc, sets half-carry and add/subtract, and keeps the other flags.
- R11: STC sets carry and clears half-carry and add/subtract. CMC inverts carry, keeps half-carry and clears add/subtract. Both give acc as the result and keep sign, zero and parity/overflow.
- R12: Codes 18 to 31 give acc as the result and return the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flg_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Result |
| flg_o | output | 8 | Updated flag byte |

## Verification
The bench targets the arithmetic boundaries 0x7F+1, 0x80-1, 0xFF+1, NEG of 0x80 and NEG of 0x00, and half-carry at nibble edges such as 0x0F+1. A design that mixed up the sign tests for overflow, or took carry from the wrong bit, gives the wrong parity/overflow or carry bit on these values. Subtract-with-borrow and the through-carry rotates are applied with both carry-in values, because a design that dropped the carry-in looks correct whenever carry is 0. The bench also checks that CMP leaves the result equal to the accumulator, that INC/DEC keep carry, that bits 5 and 3 pass through, and that unused codes change nothing.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flg_i,
  output logic [7:0] res_o,
  output logic [7:0] flg_o
);
  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,
                         OP_SUBB = 5'd3,  OP_CMP  = 5'd4,  OP_NEG  = 5'd5,
                         OP_AND  = 5'd6,  OP_OR   = 5'd7,  OP_XOR  = 5'd8,
                         OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_ROLC = 5'd11,
                         OP_RORC = 5'd12, OP_ROL9 = 5'd13, OP_ROR9 = 5'd14,
                         OP_NOT  = 5'd15, OP_STC  = 5'd16, OP_CMC  = 5'd17;

  logic cy;
  assign cy = flg_i[0];

  // adder path
  logic       add_ci;
  logic [8:0] add9;
  logic [4:0] addh;
  assign add_ci = (op_i == OP_ADDC) & cy;
  assign add9   = {1'b0, acc_i} + {1'b0, opnd_i} + {8'd0, add_ci};
  assign addh   = {1'b0, acc_i[3:0]} + {1'b0, opnd_i[3:0]} + {4'd0, add_ci};

  // subtractor path (NEG is 0 - acc)
  logic       sub_bi;
  logic [7:0] sx, sy;
  logic [8:0] sub9;
  logic [4:0] subh;
  assign sub_bi = (op_i == OP_SUBB) & cy;
  assign sx     = (op_i == OP_NEG) ? 8'h00 : acc_i;
  assign sy     = (op_i == OP_NEG) ? acc_i : opnd_i;
  assign sub9   = {1'b0, sx} - {1'b0, sy} - {8'd0, sub_bi};
  assign subh   = {1'b0, sx[3:0]} - {1'b0, sy[3:0]} - {4'd0, sub_bi};

  logic add_v, sub_v;
  assign add_v = (acc_i[7] == opnd_i[7]) && (add9[7] != acc_i[7]);
  assign sub_v = (sx[7] != sy[7]) && (sub9[7] != sx[7]);

  logic [7:0] r, fr;
  logic       fs, fz, fh, fv, fn, fc, szcalc;

  always_comb begin
    r      = acc_i;
    fr     = acc_i;
    szcalc = 1'b1;
    fs     = flg_i[7];
    fz     = flg_i[6];
    fh     = flg_i[4];
    fv     = flg_i[2];
    fn     = flg_i[1];
    fc     = flg_i[0];
    case (op_i)
      OP_ADD, OP_ADDC: begin
        r  = add9[7:0];
        fr = r;
        fh = addh[4];
        fv = add_v;
        fn = 1'b0;
        fc = add9[8];
      end
      OP_SUB, OP_SUBB, OP_NEG, OP_CMP: begin
        fr = sub9[7:0];
        r  = (op_i == OP_CMP) ? acc_i : sub9[7:0];
        fh = subh[4];
        fv = sub_v;
        fn = 1'b1;
        fc = sub9[8];
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op_i == OP_AND)     r = acc_i & opnd_i;
        else if (op_i == OP_OR) r = acc_i | opnd_i;
        else                    r = acc_i ^ opnd_i;
        fr = r;
        fh = (op_i == OP_AND);
        fv = ~^r;
        fn = 1'b0;
        fc = 1'b0;
      end
      OP_INC: begin
        r  = opnd_i + 8'd1;
        fr = r;
        fh = (opnd_i[3:0] == 4'hF);
        fv = (opnd_i == 8'h7F);
        fn = 1'b0;
      end
      OP_DEC: begin
        r  = opnd_i - 8'd1;
        fr = r;
        fh = (opnd_i[3:0] == 4'h0);
        fv = (opnd_i == 8'h80);
        fn = 1'b1;
      end
      OP_ROLC, OP_ROL9: begin
        szcalc = 1'b0;
        r  = {acc_i[6:0], (op_i == OP_ROLC) ? acc_i[7] : cy};
        fh = 1'b0;
        fn = 1'b0;
        fc = acc_i[7];
      end
      OP_RORC, OP_ROR9: begin
        szcalc = 1'b0;
        r  = {(op_i == OP_RORC) ? acc_i[0] : cy, acc_i[7:1]};
        fh = 1'b0;
        fn = 1'b0;
        fc = acc_i[0];
      end
      OP_NOT: begin
        szcalc = 1'b0;
        r  = ~acc_i;
        fh = 1'b1;
        fn = 1'b1;
      end
      OP_STC: begin
        szcalc = 1'b0;
        fh = 1'b0;
        fn = 1'b0;
        fc = 1'b1;
      end
      OP_CMC: begin
        szcalc = 1'b0;
        fn = 1'b0;
        fc = ~cy;
      end
      default: szcalc = 1'b0;
    endcase
    if (szcalc) begin
      fs = fr[7];
      fz = (fr == 8'h00);
    end
  end

  assign res_o = r;
  assign flg_o = {fs, fz, flg_i[5], fh, flg_i[3], fv, fn, fc};
endmodule

module alu8_flags_chk (
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [7:0] flg_i,
  input logic [7:0] res_o,
  input logic [7:0] flg_o
);
  logic known;
  assign known = !$isunknown({op_i, acc_i, opnd_i, flg_i});

  always_comb begin
    if (known) begin
      AST_RSV_PASS: assert (flg_o[5] == flg_i[5] && flg_o[3] == flg_i[3]); // R2
      if (op_i == 5'd4)
        AST_CMP_KEEPS_ACC: assert (res_o == acc_i); // R1
      if (op_i == 5'd9 || op_i == 5'd10)
        AST_STEP_KEEPS_CARRY: assert (flg_o[0] == flg_i[0]); // R8
      if (op_i >= 5'd11 && op_i <= 5'd14)
        AST_ROT_KEEPS_SZV: assert (flg_o[7:6] == flg_i[7:6] && flg_o[2] == flg_i[2] && flg_o[4] == 1'b0 && flg_o[1] == 1'b0); // R9
      if (op_i == 5'd17)
        AST_CMC_FLIPS: assert (flg_o[0] != flg_i[0] && res_o == acc_i); // R11
      if (op_i >= 5'd18)
        AST_UNUSED_NOP: assert (res_o == acc_i && flg_o == flg_i); // R12
      if (op_i <= 5'd10 && op_i != 5'd4)
        AST_ZERO_MATCH: assert (flg_o[6] == (res_o == 8'h00)); // R3
    end
  end
endmodule

bind alu8_flags alu8_flags_chk u_chk (.*);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [4:0] op;
  logic [7:0] acc, opnd, flg;
  logic [7:0] res_o, flg_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu8_flags u0 (.op_i(op), .acc_i(acc), .opnd_i(opnd), .flg_i(flg),
                 .res_o(res_o), .flg_o(flg_o));

  function automatic bit even_par(input int v);
    int k = 0;
    for (int i = 0; i < 8; i++) k += (v >> i) & 1;
    return (k % 2) == 0;
  endfunction

  function automatic int sx8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {result, flags}
  function automatic logic [15:0] model(input int o, input int a, input int b, input logic [7:0] f);
    int r = a;
    int fr = a;
    int c = f[0];
    bit S = f[7], Z = f[6], H = f[4], V = f[2], N = f[1], C = f[0];
    bit sz = 0;
    int t, sv;
    case (o)
      0, 1: begin
        t = a + b + ((o == 1) ? c : 0);
        sv = sx8(a) + sx8(b) + ((o == 1) ? c : 0);
        r = t % 256; fr = r; sz = 1;
        C = t > 255; H = ((a % 16) + (b % 16) + ((o == 1) ? c : 0)) > 15;
        V = (sv > 127) || (sv < -128); N = 0;
      end
      2, 3, 4, 5: begin
        int x = (o == 5) ? 0 : a;
        int y = (o == 5) ? a : b;
        int bi = (o == 3) ? c : 0;
        t = x - y - bi;
        sv = sx8(x) - sx8(y) - bi;
        fr = (t + 512) % 256; r = (o == 4) ? a : fr; sz = 1;
        C = t < 0; H = ((x % 16) - (y % 16) - bi) < 0;
        V = (sv > 127) || (sv < -128); N = 1;
      end
      6, 7, 8: begin
        r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (a ^ b);
        fr = r; sz = 1; C = 0; N = 0; H = (o == 6); V = even_par(r);
      end
      9: begin
        r = (b + 1) % 256; fr = r; sz = 1;
        H = (b % 16) == 15; V = (b == 127); N = 0;
      end
      10: begin
        r = (b + 255) % 256; fr = r; sz = 1;
        H = (b % 16) == 0; V = (b == 128); N = 1;
      end
      11: begin r = ((a * 2) % 256) + a / 128; C = a / 128; H = 0; N = 0; end
      12: begin r = a / 2 + (a % 2) * 128;     C = a % 2;   H = 0; N = 0; end
      13: begin r = ((a * 2) % 256) + c;       C = a / 128; H = 0; N = 0; end
      14: begin r = a / 2 + c * 128;           C = a % 2;   H = 0; N = 0; end
      15: begin r = 255 - a; H = 1; N = 1; end
      16: begin C = 1; H = 0; N = 0; end
      17: begin C = !f[0]; N = 0; end
      default: ;
    endcase
    if (sz) begin S = fr >= 128; Z = fr == 0; end
    return {r[7:0], S, Z, f[5], H, f[3], V, N, C};
  endfunction

  task automatic apply(input int o, input int a, input int b, input logic [7:0] f, input string req);
    logic [15:0] exp;
    @(posedge clk);
    op = o[4:0]; acc = a[7:0]; opnd = b[7:0]; flg = f;
    exp = model(o, a, b, f);
    @(negedge clk);
    n_vec++;
    if ({res_o, flg_o} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h f=%h: got res=%h flg=%h, expected res=%h flg=%h",
               req, o, a[7:0], b[7:0], f, res_o, flg_o, exp[15:8], exp[7:0]);
    end
  endtask

  task automatic expect_eq(input logic [7:0] got, input logic [7:0] want, input string req);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    op = 5'd18; acc = 8'h00; opnd = 8'h00; flg = 8'h00;
    @(negedge clk);
    // R12 initial state: unused code leaves everything alone
    expect_eq(res_o, 8'h00, "R12 reset res");
    expect_eq(flg_o, 8'h00, "R12 reset flags");

    // directed corners
    apply(0, 8'h7F, 8'h01, 8'h00, "R5 7F+1 overflow");
    expect_eq(flg_o, 8'h94, "R5 7F+1 flags");
    apply(0, 8'hFF, 8'h01, 8'h00, "R4 FF+1 carry zero");
    expect_eq(flg_o, 8'h51, "R4 FF+1 flags");
    apply(0, 8'h0F, 8'h01, 8'h00, "R4 half carry");
    apply(2, 8'h80, 8'h01, 8'h00, "R5 80-1 overflow");
    expect_eq(flg_o, 8'h16, "R5 80-1 flags");
    apply(5, 8'h80, 8'h00, 8'h00, "R5 NEG 80");
    expect_eq(flg_o, 8'h87, "R5 NEG 80 flags");
    apply(5, 8'h00, 8'h00, 8'h01, "R4 NEG 00 no borrow");
    apply(4, 8'h42, 8'h42, 8'h00, "R1 CMP equal keeps acc");
    expect_eq(res_o, 8'h42, "R1 CMP result");
    apply(3, 8'h00, 8'h00, 8'h01, "R4 SUBB borrow in");
    apply(1, 8'hFF, 8'h00, 8'h01, "R1 ADDC carry in");
    apply(6, 8'hF0, 8'h0F, 8'hFF, "R7 AND zero parity");
    expect_eq(flg_o, 8'h7C, "R7 AND flags");
    apply(8, 8'h01, 8'h00, 8'h00, "R7 XOR odd parity");
    apply(7, 8'h03, 8'h00, 8'h01, "R7 OR even parity");
    apply(9, 8'h00, 8'h7F, 8'h01, "R8 INC 7F keeps carry");
    expect_eq(flg_o, 8'h95, "R8 INC 7F flags");
    apply(10, 8'h00, 8'h80, 8'h00, "R8 DEC 80");
    apply(10, 8'h00, 8'h01, 8'h01, "R8 DEC to zero");
    apply(13, 8'h80, 8'h00, 8'h01, "R9 ROL9 carry in");
    expect_eq(res_o, 8'h01, "R9 ROL9 result");
    apply(14, 8'h01, 8'h00, 8'h00, "R9 ROR9 carry out");
    apply(11, 8'h81, 8'h00, 8'hC4, "R9 ROLC keeps SZV");
    apply(12, 8'h01, 8'h00, 8'h00, "R9 RORC");
    apply(15, 8'h5A, 8'h00, 8'h00, "R10 NOT");
    apply(16, 8'h33, 8'h00, 8'h12, "R11 STC");
    apply(17, 8'h33, 8'h00, 8'h11, "R11 CMC");
    apply(21, 8'h9C, 8'h77, 8'hA5, "R12 unused code");
    apply(31, 8'h01, 8'h02, 8'h3C, "R12 unused code 31");
    apply(0, 8'h10, 8'h20, 8'h28, "R2 reserved bits pass");

    // random sweep over all codes and both carry-in values
    for (int o = 0; o < 32; o++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int k = 0; k < 150; k++) begin
          logic [7:0] f;
          f = $urandom();
          f[0] = cin[0];
          apply(o, $urandom() % 256, $urandom() % 256, f, "R1 R3 R6 random sweep");
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule